// File: doc/BRIEF.md
# Hypervisor Facility Gate

This unit sits next to the execute stage of a 64-bit processor and rules on four privileged guest operations: sending a doorbell message, clearing a doorbell message, and reading or writing the directed-doorbell status register. Each operation needs supervisor privilege. When hypervisor mode is built in and the processor is not in hypervisor state, the operation also needs an enable bit in the hypervisor facility status and control register (HFSCR). If that bit is clear, the unit does not let the operation proceed. It raises a hypervisor facility-unavailable interrupt instead.

A decoded-operation strobe and its operation code are sampled together with the current MSR, the current HFSCR and the instruction address. One cycle later the unit presents a verdict. There are three possible verdicts: proceed, privilege fault, or hypervisor fault. On a hypervisor fault the unit also presents the values the pipeline loads to enter the hypervisor handler: the rewritten HFSCR with its cause field set, the hypervisor save registers, the new MSR and the vector address. The unit does not deliver messages, does not store the doorbell register, and does not handle other interrupt classes.

Top module: `hv_gate_unit`

## Requirements
- R1: All outputs are registered and appear on the clock edge after the strobe (`opValid`) is sampled. In a cycle that follows no strobe, every output is zero.
- R2: If MSR bit 14 (problem state) is 1, the strobe raises `privFault` only. `hfscrOut` equals the HFSCR input. `hsrr0`, `hsrr1`, `msrNew` and `vector` are zero. The facility check is not applied.
- R3: In supervisor state with MSR bit 60 (hypervisor) set, the operation is allowed whatever the HFSCR holds.
- R4: In supervisor state with MSR bit 60 clear and HFSCR bit 10 (LSB numbering) set, the operation is allowed and `hfscrOut` equals the HFSCR input.
- R5: With `HV_IMPL=1`, in supervisor state with MSR bit 60 clear and HFSCR bit 10 clear, `hvFault` is raised and `allow` stays low.
- R6: On a hypervisor fault, `hfscrOut` bits 63:56 hold 0x0A whatever they held before. All other bits equal the HFSCR input.
- R7: On a hypervisor fault, `hsrr0` equals the instruction address of the trapping operation and `hsrr1` equals the MSR before the trap.
- R8: On a hypervisor fault, `msrNew` has bit 60 set and bit 1 (recoverable interrupt) copied from the old MSR. All other bits are zero.
- R9: `vector` is 0xF80 on a hypervisor fault and zero otherwise.
- R10: With `HV_IMPL=0` no facility check is made. Every operation in supervisor state is allowed.
- R11: Operation codes 0 (message send), 1 (message clear), 2 (doorbell-status read) and 3 (doorbell-status write) are all gated the same way under the default `GATED_OPS` mask.
- R12: Each strobe raises exactly one of `allow`, `privFault` and `hvFault`. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Decoded gated operation present this cycle |
| opCode | input | 2 | Operation code: 0 send, 1 clear, 2 status read, 3 status write |
| msr | input | 64 | Current machine state register |
| hfscr | input | 64 | Current hypervisor facility status and control register |
| instAddr | input | 64 | Address of the operation's instruction |
| allow | output | 1 | Operation may take effect |
| privFault | output | 1 | Privilege fault (problem state) |
| hvFault | output | 1 | Hypervisor facility-unavailable interrupt |
| hfscrOut | output | 64 | HFSCR value to write back |
| hsrr0 | output | 64 | Hypervisor save/restore register 0 value |
| hsrr1 | output | 64 | Hypervisor save/restore register 1 value |
| msrNew | output | 64 | MSR value on interrupt entry |
| vector | output | 64 | Interrupt vector address |

## Verification
Every result is due exactly one clock edge after the strobe is sampled. The bench drives inputs on a falling edge, drops the strobe on the next falling edge, and compares all outputs there, when the single register stage has been loaded. It checks again one falling edge later, when the outputs must have gone back to zero. The sweep covers every combination of operation code, privilege, hypervisor state, enable bit and recoverable bit. It runs against two instances, one with hypervisor mode built in and one without.

// File: rtl/hvg_pkg.sv
package hvg_pkg;

  typedef enum logic [1:0] {
    OP_MSG_SEND    = 2'd0,
    OP_MSG_CLEAR   = 2'd1,
    OP_DBELL_READ  = 2'd2,
    OP_DBELL_WRITE = 2'd3
  } gate_op_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;   // a strobe was decided this cycle
    logic grant;     // operation allowed
    logic privTrap;  // problem-state fault
    logic hvTrap;    // facility-unavailable interrupt
  } gate_strobe_t;

endpackage

// File: rtl/hvg_ctrl.sv
module hvg_ctrl
  import hvg_pkg::*;
#(
  parameter bit       HV_IMPL   = 1'b1,
  parameter bit [3:0] GATED_OPS = 4'b1111
) (
  input  logic         opValid,
  input  gate_op_e     opCode,
  input  logic         msrPr,
  input  logic         msrHv,
  input  logic         facEnable,
  output gate_strobe_t strobe
);

  logic checkOn;
  logic opGated;
  logic facilityTrap;

  generate
    if (HV_IMPL) begin : g_hvCheck
      assign checkOn = !msrHv;
    end else begin : g_noHvCheck
      logic unusedHv;
      assign unusedHv = msrHv;
      assign checkOn  = 1'b0;
    end
  endgenerate

  assign opGated = GATED_OPS[opCode];

  always_comb begin
    facilityTrap    = opValid && !msrPr && opGated && checkOn && !facEnable;
    strobe.capture  = opValid;
    strobe.privTrap = opValid && msrPr;
    strobe.hvTrap   = facilityTrap;
    strobe.grant    = opValid && !msrPr && !facilityTrap;
  end

endmodule

// File: rtl/hvg_datapath.sv
module hvg_datapath
  import hvg_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter int              HV_BIT     = 60,
  parameter int              RI_BIT     = 1,
  parameter int              CAUSE_LSB  = 56,
  parameter int              CAUSE_W    = 8,
  parameter logic [7:0]      CAUSE_CODE = 8'h0A,
  parameter logic [XLEN-1:0] VECTOR     = 'h0F80
) (
  input  logic            clk,
  input  logic            rstN,
  input  gate_strobe_t    strobe,
  input  logic [XLEN-1:0] msr,
  input  logic [XLEN-1:0] hfscr,
  input  logic [XLEN-1:0] instAddr,
  output logic            allow,
  output logic            privFault,
  output logic            hvFault,
  output logic [XLEN-1:0] hfscrOut,
  output logic [XLEN-1:0] hsrr0,
  output logic [XLEN-1:0] hsrr1,
  output logic [XLEN-1:0] msrNew,
  output logic [XLEN-1:0] vector
);

  logic [XLEN-1:0] trapHfscr;
  logic [XLEN-1:0] entryMsr;

  always_comb begin
    trapHfscr = hfscr;
    trapHfscr[CAUSE_LSB +: CAUSE_W] = CAUSE_W'(CAUSE_CODE);
    entryMsr = '0;
    entryMsr[HV_BIT] = 1'b1;
    entryMsr[RI_BIT] = msr[RI_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allow     <= 1'b0;
      privFault <= 1'b0;
      hvFault   <= 1'b0;
      hfscrOut  <= '0;
      hsrr0     <= '0;
      hsrr1     <= '0;
      msrNew    <= '0;
      vector    <= '0;
    end else begin
      allow     <= strobe.grant;
      privFault <= strobe.privTrap;
      hvFault   <= strobe.hvTrap;
      hfscrOut  <= !strobe.capture ? '0 : (strobe.hvTrap ? trapHfscr : hfscr);
      hsrr0     <= strobe.hvTrap ? instAddr : '0;
      hsrr1     <= strobe.hvTrap ? msr : '0;
      msrNew    <= strobe.hvTrap ? entryMsr : '0;
      vector    <= strobe.hvTrap ? VECTOR : '0;
    end
  end

endmodule

// File: rtl/hv_gate_unit.sv
module hv_gate_unit
  import hvg_pkg::*;
#(
  parameter int              XLEN       = 64,
  parameter bit              HV_IMPL    = 1'b1,
  parameter bit [3:0]        GATED_OPS  = 4'b1111,
  parameter int              PR_BIT     = 14,
  parameter int              HV_BIT     = 60,
  parameter int              RI_BIT     = 1,
  parameter int              EN_BIT     = 10,
  parameter int              CAUSE_LSB  = 56,
  parameter int              CAUSE_W    = 8,
  parameter logic [7:0]      CAUSE_CODE = 8'h0A,
  parameter logic [XLEN-1:0] VECTOR     = 'h0F80
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [1:0]      opCode,
  input  logic [XLEN-1:0] msr,
  input  logic [XLEN-1:0] hfscr,
  input  logic [XLEN-1:0] instAddr,
  output logic            allow,
  output logic            privFault,
  output logic            hvFault,
  output logic [XLEN-1:0] hfscrOut,
  output logic [XLEN-1:0] hsrr0,
  output logic [XLEN-1:0] hsrr1,
  output logic [XLEN-1:0] msrNew,
  output logic [XLEN-1:0] vector
);

  gate_strobe_t strobe;

  hvg_ctrl #(
    .HV_IMPL  (HV_IMPL),
    .GATED_OPS(GATED_OPS)
  ) u_ctrl (
    .opValid  (opValid),
    .opCode   (gate_op_e'(opCode)),
    .msrPr    (msr[PR_BIT]),
    .msrHv    (msr[HV_BIT]),
    .facEnable(hfscr[EN_BIT]),
    .strobe   (strobe)
  );

  hvg_datapath #(
    .XLEN      (XLEN),
    .HV_BIT    (HV_BIT),
    .RI_BIT    (RI_BIT),
    .CAUSE_LSB (CAUSE_LSB),
    .CAUSE_W   (CAUSE_W),
    .CAUSE_CODE(CAUSE_CODE),
    .VECTOR    (VECTOR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .msr      (msr),
    .hfscr    (hfscr),
    .instAddr (instAddr),
    .allow    (allow),
    .privFault(privFault),
    .hvFault  (hvFault),
    .hfscrOut (hfscrOut),
    .hsrr0    (hsrr0),
    .hsrr1    (hsrr1),
    .msrNew   (msrNew),
    .vector   (vector)
  );

endmodule

// File: rtl/hvg_checker.sv
module hvg_checker #(
  parameter int              XLEN       = 64,
  parameter int              PR_BIT     = 14,
  parameter int              HV_BIT     = 60,
  parameter int              RI_BIT     = 1,
  parameter int              CAUSE_LSB  = 56,
  parameter int              CAUSE_W    = 8,
  parameter logic [7:0]      CAUSE_CODE = 8'h0A,
  parameter logic [XLEN-1:0] VECTOR     = 'h0F80
) (
  input logic            clk,
  input logic            rstN,
  input logic            opValid,
  input logic [XLEN-1:0] msr,
  input logic [XLEN-1:0] instAddr,
  input logic            allow,
  input logic            privFault,
  input logic            hvFault,
  input logic [XLEN-1:0] hfscrOut,
  input logic [XLEN-1:0] hsrr0,
  input logic [XLEN-1:0] hsrr1,
  input logic [XLEN-1:0] msrNew,
  input logic [XLEN-1:0] vector
);

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> $countones({allow, privFault, hvFault}) == 1); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !(allow || privFault || hvFault) && hfscrOut == '0); // R1

  AST_PRIV_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && msr[PR_BIT]) |=> privFault && !hvFault); // R2

  AST_HV_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !msr[PR_BIT] && msr[HV_BIT]) |=> allow); // R3

  AST_TRAP_NO_ALLOW: assert property (@(posedge clk) disable iff (!rstN)
    hvFault |-> !allow); // R5

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rstN)
    hvFault |-> hfscrOut[CAUSE_LSB +: CAUSE_W] == CAUSE_W'(CAUSE_CODE)); // R6

  AST_SAVE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (!hvFault || (hsrr0 == $past(instAddr) && hsrr1 == $past(msr)))); // R7

  AST_RI_INHERIT: assert property (@(posedge clk) disable iff (!rstN)
    hvFault |-> msrNew[HV_BIT] && msrNew[RI_BIT] == hsrr1[RI_BIT]); // R8

  AST_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    hvFault |-> vector == VECTOR); // R9

endmodule

bind hv_gate_unit hvg_checker #(
  .XLEN      (XLEN),
  .PR_BIT    (PR_BIT),
  .HV_BIT    (HV_BIT),
  .RI_BIT    (RI_BIT),
  .CAUSE_LSB (CAUSE_LSB),
  .CAUSE_W   (CAUSE_W),
  .CAUSE_CODE(CAUSE_CODE),
  .VECTOR    (VECTOR)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .msr      (msr),
  .instAddr (instAddr),
  .allow    (allow),
  .privFault(privFault),
  .hvFault  (hvFault),
  .hfscrOut (hfscrOut),
  .hsrr0    (hsrr0),
  .hsrr1    (hsrr1),
  .msrNew   (msrNew),
  .vector   (vector)
);

// File: tb/tb_hv_gate_unit.sv
`timescale 1ns/1ps
module tb_hv_gate_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = '0;
  logic [63:0] msr = '0, hfscr = '0, instAddr = '0;

  logic        allowA, privA, hvA;
  logic [63:0] hfscrA, s0A, s1A, msrA, vecA;
  logic        allowB, privB, hvB;
  logic [63:0] hfscrB, s0B, s1B, msrB, vecB;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  hv_gate_unit #(.HV_IMPL(1'b1)) dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .msr(msr), .hfscr(hfscr), .instAddr(instAddr),
    .allow(allowA), .privFault(privA), .hvFault(hvA), .hfscrOut(hfscrA),
    .hsrr0(s0A), .hsrr1(s1A), .msrNew(msrA), .vector(vecA));

  hv_gate_unit #(.HV_IMPL(1'b0)) dutNoHv (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .msr(msr), .hfscr(hfscr), .instAddr(instAddr),
    .allow(allowB), .privFault(privB), .hvFault(hvB), .hfscrOut(hfscrB),
    .hsrr0(s0B), .hsrr1(s1B), .msrNew(msrB), .vector(vecB));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    chk("R1", {tag, " flagsA"}, {61'd0, allowA, privA, hvA}, 64'd0);
    chk("R1", {tag, " hfscrA"}, hfscrA, 64'd0);
    chk("R1", {tag, " vecA"},   vecA,   64'd0);
    chk("R1", {tag, " flagsB"}, {61'd0, allowB, privB, hvB}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset clears outputs
    repeat (3) @(negedge clk);
    chk("R12", "reset flags", {58'd0, allowA, privA, hvA, allowB, privB, hvB}, 64'd0);
    chk("R12", "reset hfscr", hfscrA, 64'd0);
    chk("R12", "reset save", s0A | s1A | msrA | vecA, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("post-reset");

    for (int pass = 0; pass < 3; pass++) begin
      for (int idx = 0; idx < 64; idx++) begin
        logic [63:0] m, h, pc;
        logic pr, hv, en, ri, expHv, expAllowA;
        logic [63:0] expHfscr;
        pr = idx[2]; hv = idx[3]; en = idx[4]; ri = idx[5];
        m  = {$urandom, $urandom};
        h  = {$urandom, $urandom};
        pc = {$urandom, $urandom} & ~64'h3;
        if (pass == 0) h[63:56] = 8'hFF; // stale cause must be replaced
        m[14] = pr; m[60] = hv; m[1] = ri; h[10] = en;
        @(negedge clk);
        opValid = 1'b1; opCode = idx[1:0];
        msr = m; hfscr = h; instAddr = pc;
        @(negedge clk);
        opValid = 1'b0;
        expHv     = !pr && !hv && !en;
        expAllowA = !pr && !expHv;
        expHfscr  = expHv ? {8'h0A, h[55:0]} : h;
        // instance with hypervisor mode
        chk("R2", "privFault", {63'd0, privA}, {63'd0, pr});
        chk(hv ? "R3" : "R4", "allow", {63'd0, allowA}, {63'd0, expAllowA});
        chk("R5 R11", "hvFault", {63'd0, hvA}, {63'd0, expHv});
        chk("R12", "one verdict", 64'(allowA + privA + hvA), 64'd1);
        chk(expHv ? "R6" : "R4", "hfscrOut", hfscrA, expHfscr);
        chk("R7", "hsrr0", s0A, expHv ? pc : 64'd0);
        chk("R7", "hsrr1", s1A, expHv ? m : 64'd0);
        chk("R8", "msrNew", msrA,
            expHv ? ((64'd1 << 60) | (64'(ri) << 1)) : 64'd0);
        chk("R9", "vector", vecA, expHv ? 64'hF80 : 64'd0);
        // instance without hypervisor mode
        chk("R10", "allow noHv", {62'd0, allowB, hvB}, {62'd0, !pr, 1'b0});
        chk("R10", "hfscr noHv", hfscrB, h);
        chk("R10", "save noHv", s0B | s1B | msrB | vecB, 64'd0);
        @(negedge clk);
        checkIdle("after strobe");
      end
    end

    // R1 back-to-back strobes: trap then allow
    @(negedge clk);
    opValid = 1'b1; opCode = 2'd3;
    msr = 64'h2; hfscr = 64'h0; instAddr = 64'h1000;
    @(negedge clk);
    chk("R1", "b2b first trap", {63'd0, hvA}, 64'd1);
    chk("R7", "b2b hsrr0", s0A, 64'h1000);
    hfscr = 64'h400; instAddr = 64'h1004;
    @(negedge clk);
    opValid = 1'b0;
    chk("R1", "b2b second allow", {62'd0, allowA, hvA}, 64'd2);
    chk("R1", "b2b hsrr0 cleared", s0A, 64'd0);
    @(negedge clk);
    checkIdle("end");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule